// File: doc/BRIEF.md
# Write-Combining Store Gather Buffer

This block sits between a core's store path and one write port of a cache. It gathers individual word stores into line-sized entries. Each entry covers one 64-byte aligned line and goes to the cache as a single line write, with a 64-bit byte mask marking the bytes that the gathered stores actually wrote. Two hardware threads share the entries. A store from either thread merges into any open entry for the same line, whichever thread opened it.

Entries drain strictly in the order they were opened. A store that merges into an older entry keeps that entry's place in the queue, so its data can reach the cache ahead of stores that came before it in program order. A barrier pulse closes every open entry to further merging. Stores issued after the barrier then open fresh entries, which drain behind everything gathered before it. When the cache reports that the line being written is not present, draining stops until the fill completes.

Top module: `wc_gather_buf`

## Requirements
- R1: Synchronous active-high reset empties the buffer. After reset `lw_valid` is 0 and `st_ready` is 1.
- R2: A store to a line with no open entry opens a new entry. Entries are presented on the line-write port in the order they were opened.
- R3: A store to a line that has an open entry merges into it. The mask and data become the union of both stores, and the entry keeps its queue position. Stores to 0x1000, 0x2000 and 0x1004 therefore produce line 0x1000 (mask 0xFF) before line 0x2000.
- R4: A line write carries `lw_addr` = address bits [31:6]. Mask bit b and data bits [8b+7:8b] describe byte b of the line. A store at word `st_addr[5:2]` = w with enable bit k writes line byte 4w+k from data bits [8k+7:8k]. Bytes not written read as zero.
- R5: Both threads merge into a shared entry. `lw_threads` bit t is 1 when thread t wrote into the line.
- R6: A barrier seals all open entries. A store in the same cycle as the barrier, or any later store, to a sealed line opens a new entry that drains after the sealed one.
- R7: The buffer holds 8 entries. With all 8 open, a store that cannot merge sees `st_ready` = 0 until an entry drains. A store that merges is still accepted.
- R8: The cache takes a line when `lw_valid` and `lw_ready` are both 1. `lw_valid` then stays 0 until `rsp_valid`. A hit response (`rsp_hit` = 1) frees the entry.
- R9: A miss response (`rsp_hit` = 0) holds the entry, and `lw_valid` stays 0 until `fill_done`. The fill completes the write and frees the entry.
- R10: Once its line has been taken by the cache, the head entry no longer merges. A store to that line opens a new entry.
- R11: While `lw_valid` is 1 and `lw_ready` is 0, `lw_valid` stays 1 and `lw_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | ADDR_W-2 | Word address of the store (byte address bits [31:2]) |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Byte enables |
| st_thread | input | 1 | Issuing hardware thread |
| barrier | input | 1 | Ordering point: seal all open entries |
| lw_valid | output | 1 | Head line write presented |
| lw_ready | input | 1 | Cache takes the presented line |
| lw_addr | output | ADDR_W-6 | Line address |
| lw_data | output | 512 | Line data |
| lw_mask | output | 64 | Byte mask of the line |
| lw_threads | output | 2 | Threads that wrote into the line |
| rsp_valid | input | 1 | Cache response to the taken line |
| rsp_hit | input | 1 | 1 = line present, 0 = miss |
| fill_done | input | 1 | Miss fill finished |

## Verification
The hardest situation to reach from the ports is a full buffer that still accepts a merging store while rejecting a new line. It is reached by holding `lw_ready` low while eight distinct lines are stored, then offering a ninth line and a store to a middle entry on the same request. A second hard case is a store that arrives while the head line waits for its cache response. The bench raises `lw_ready` for exactly one cycle and issues the store before answering. A sweep over every word slot and every byte-enable pattern checks where the data lands in the line.

// File: rtl/wc_gather_buf.sv
module wc_gather_buf #(
  parameter int ENTRIES    = 8,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int THREADS    = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              st_valid,
  output logic                              st_ready,
  input  logic [ADDR_W-1:2]                 st_addr,
  input  logic [31:0]                       st_data,
  input  logic [3:0]                        st_be,
  input  logic [$clog2(THREADS)-1:0]        st_thread,
  input  logic                              barrier,
  output logic                              lw_valid,
  input  logic                              lw_ready,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] lw_addr,
  output logic [LINE_BYTES*8-1:0]           lw_data,
  output logic [LINE_BYTES-1:0]             lw_mask,
  output logic [THREADS-1:0]                lw_threads,
  input  logic                              rsp_valid,
  input  logic                              rsp_hit,
  input  logic                              fill_done
);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFS_W;
  localparam int WSEL_W = OFS_W - 2;
  localparam int PTR_W = $clog2(ENTRIES);
  localparam int CNT_W = PTR_W + 1;
  localparam int LINE_BITS = LINE_BYTES * 8;

  typedef enum logic [1:0] {S_IDLE, S_RSP, S_FILL} drain_t;

  drain_t                 state;
  logic [ENTRIES-1:0]     vld, seal, hitv;
  logic [TAG_W-1:0]       tag_q [ENTRIES];
  logic [LINE_BYTES-1:0]  msk_q [ENTRIES];
  logic [LINE_BITS-1:0]   dat_q [ENTRIES];
  logic [THREADS-1:0]     thr_q [ENTRIES];
  logic [PTR_W-1:0]       head, tail;
  logic [CNT_W-1:0]       cnt;

  wire [TAG_W-1:0]      st_tag = st_addr[ADDR_W-1:OFS_W];
  wire [WSEL_W-1:0]     wsel   = st_addr[OFS_W-1:2];
  wire [LINE_BYTES-1:0] wmask  = LINE_BYTES'(st_be) << {wsel, 2'b00};
  wire [LINE_BITS-1:0]  wdata  = LINE_BITS'(st_data) << {wsel, 5'b00000};
  wire [THREADS-1:0]    thr_bit = THREADS'(1) << st_thread;

  assign lw_valid = (state == S_IDLE) && (cnt != '0);
  wire head_busy = (state != S_IDLE) || (lw_valid && lw_ready);

  always_comb
    for (int i = 0; i < ENTRIES; i++)
      hitv[i] = vld[i] && !seal[i] && !barrier && (tag_q[i] == st_tag) &&
                !(head_busy && (PTR_W'(i) == head));

  wire mrg   = |hitv;
  wire full  = (cnt == CNT_W'(ENTRIES));
  assign st_ready = mrg || !full;
  wire do_st = st_valid && st_ready;
  wire alloc = do_st && !mrg;
  wire pop   = ((state == S_RSP) && rsp_valid && rsp_hit) ||
               ((state == S_FILL) && fill_done);

  assign lw_addr    = tag_q[head];
  assign lw_data    = dat_q[head];
  assign lw_mask    = msk_q[head];
  assign lw_threads = thr_q[head];

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (32'(p) == ENTRIES - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0; seal <= '0; head <= '0; tail <= '0; cnt <= '0;
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (lw_valid && lw_ready) state <= S_RSP;
        S_RSP:   if (rsp_valid) state <= rsp_hit ? S_IDLE : S_FILL;
        S_FILL:  if (fill_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (barrier) seal <= seal | vld;
      if (pop) begin
        vld[head] <= 1'b0;
        head <= inc(head);
      end
      if (alloc) begin
        vld[tail]  <= 1'b1;
        seal[tail] <= 1'b0;
        tail <= inc(tail);
      end
      cnt <= cnt + CNT_W'(alloc) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk)
    for (int i = 0; i < ENTRIES; i++) begin
      if (alloc && (PTR_W'(i) == tail)) begin
        tag_q[i] <= st_tag;
        msk_q[i] <= wmask;
        thr_q[i] <= thr_bit;
        for (int b = 0; b < LINE_BYTES; b++)
          dat_q[i][8*b +: 8] <= wmask[b] ? wdata[8*b +: 8] : 8'h00;
      end else if (do_st && hitv[i]) begin
        msk_q[i] <= msk_q[i] | wmask;
        thr_q[i] <= thr_q[i] | thr_bit;
        for (int b = 0; b < LINE_BYTES; b++)
          if (wmask[b]) dat_q[i][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
endmodule

// File: rtl/wc_gather_buf_chk.sv
module wc_gather_buf_chk #(
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 4,
  parameter int TAG_W   = 26
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic             st_valid,
  input logic             st_ready,
  input logic             lw_valid,
  input logic             lw_ready,
  input logic [TAG_W-1:0] lw_addr,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             fill_done
);
  logic rsp_wait, miss_pend;

  always_ff @(posedge clk)
    if (rst) begin
      rsp_wait <= 1'b0; miss_pend <= 1'b0;
    end else begin
      if (lw_valid && lw_ready) rsp_wait <= 1'b1;
      else if (rsp_valid) rsp_wait <= 1'b0;
      if (rsp_wait && rsp_valid && !rsp_hit) miss_pend <= 1'b1;
      else if (fill_done) miss_pend <= 1'b0;
    end

  AST_RESET_EMPTY: assert property (@(posedge clk) $past(rst) |-> (cnt == '0) && !lw_valid); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(ENTRIES)); // R7
  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (rst) st_valid && !st_ready |-> cnt == CNT_W'(ENTRIES)); // R7
  AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (rst) rsp_wait |-> !lw_valid); // R8
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (rst) miss_pend |-> !lw_valid); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst) lw_valid && !lw_ready |=> lw_valid && $stable(lw_addr)); // R11
endmodule

bind wc_gather_buf wc_gather_buf_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .st_valid(st_valid), .st_ready(st_ready),
  .lw_valid(lw_valid), .lw_ready(lw_ready), .lw_addr(lw_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .fill_done(fill_done)
);

// File: tb/test_wc_gather_buf.sv
`timescale 1ns/1ps
module test_wc_gather_buf;
  logic clk = 0, rst = 1;
  logic st_valid = 0, st_ready, st_thread = 0, barrier = 0;
  logic [31:2] st_addr = '0;
  logic [31:0] st_data = '0;
  logic [3:0] st_be = '0;
  logic lw_valid, lw_ready = 0, rsp_valid = 0, rsp_hit = 0, fill_done = 0;
  logic [25:0] lw_addr;
  logic [511:0] lw_data;
  logic [63:0] lw_mask;
  logic [1:0] lw_threads;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wc_gather_buf i_wc_gather_buf (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be), .st_thread(st_thread), .barrier(barrier),
    .lw_valid(lw_valid), .lw_ready(lw_ready), .lw_addr(lw_addr), .lw_data(lw_data),
    .lw_mask(lw_mask), .lw_threads(lw_threads), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .fill_done(fill_done));

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] ln(input int wo, input logic [31:0] d, input logic [3:0] be);
    logic [511:0] r = '0;
    for (int k = 0; k < 4; k++) if (be[k]) r[(wo*4+k)*8 +: 8] = d[8*k +: 8];
    return r;
  endfunction

  function automatic logic [63:0] mk(input int wo, input logic [3:0] be);
    return 64'(be) << (wo*4);
  endfunction

  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                       input logic thr, input logic bar);
    @(negedge clk);
    st_valid = 1; st_addr = a[31:2]; st_data = d; st_be = be; st_thread = thr; barrier = bar;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    st_valid = 0; barrier = 0;
  endtask

  task automatic drain(input logic [31:0] a, input logic [63:0] m, input logic [511:0] d,
                       input logic [1:0] thr, input bit miss, input string req);
    @(negedge clk);
    chk(lw_valid == 1, {req, " lw_valid"}, 512'(lw_valid), 512'(1));
    chk(lw_addr == a[31:6], {req, " lw_addr"}, 512'(lw_addr), 512'(a[31:6]));
    chk(lw_mask == m, {req, " lw_mask"}, 512'(lw_mask), 512'(m));
    chk(lw_data == d, {req, " lw_data"}, lw_data, d);
    chk(lw_threads == thr, {req, " lw_threads"}, 512'(lw_threads), 512'(thr));
    lw_ready = 1;
    @(posedge clk); #1 lw_ready = 0;
    @(negedge clk);
    chk(lw_valid == 0, "R8 quiet awaiting response", 512'(lw_valid), 512'(0));
    rsp_valid = 1; rsp_hit = !miss;
    @(posedge clk); #1 rsp_valid = 0;
    if (miss) begin
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk(lw_valid == 0, "R9 held on miss", 512'(lw_valid), 512'(0));
      end
      fill_done = 1;
      @(posedge clk); #1 fill_done = 0;
    end
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    chk(lw_valid == 0, req, 512'(lw_valid), 512'(0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(lw_valid == 0, "R1 lw_valid after reset", 512'(lw_valid), 512'(0));
    chk(st_ready == 1, "R1 st_ready after reset", 512'(st_ready), 512'(1));

    // R4 sweep over word slot and byte enables
    for (int wo = 0; wo < 16; wo++)
      for (int be = 1; be < 16; be++) begin
        logic [31:0] a, d;
        a = 32'h0010_0000 + 32'((wo*15 + be) * 64 + wo*4);
        d = (32'h0102_0304 * 32'(be + 1)) ^ 32'(wo * 32'h0011_0000);
        store(a, d, 4'(be), 0, 0);
        drain(a, mk(wo, 4'(be)), ln(wo, d, 4'(be)), 2'b01, 0, "R4 sweep");
      end
    expect_empty("R8 empty after sweep");

    // R3 / R2 merge keeps queue slot
    store(32'h1000, 32'hAAAA_0001, 4'hF, 0, 0);
    store(32'h2000, 32'hBBBB_0002, 4'hF, 0, 0);
    store(32'h1004, 32'hCCCC_0003, 4'hF, 0, 0);
    drain(32'h1000, 64'hFF, ln(0, 32'hAAAA_0001, 4'hF) | ln(1, 32'hCCCC_0003, 4'hF), 2'b01, 0, "R3 merged first");
    drain(32'h2000, 64'hF, ln(0, 32'hBBBB_0002, 4'hF), 2'b01, 0, "R2 second line");
    expect_empty("R3 no extra entry");

    // R5 cross-thread merge
    store(32'h3000, 32'h1111_2222, 4'h3, 0, 0);
    store(32'h3008, 32'h3333_4444, 4'hC, 1, 0);
    drain(32'h3000, mk(0, 4'h3) | mk(2, 4'hC), ln(0, 32'h1111_2222, 4'h3) | ln(2, 32'h3333_4444, 4'hC), 2'b11, 0, "R5 shared entry");
    expect_empty("R5 one entry only");

    // R6 barrier: separate pulse, then same-cycle
    store(32'h4000, 32'h0000_4000, 4'hF, 0, 0);
    @(negedge clk); barrier = 1; @(posedge clk); #1 barrier = 0;
    store(32'h4004, 32'h0000_4004, 4'hF, 1, 0);
    store(32'h5000, 32'h0000_5000, 4'hF, 0, 0);
    store(32'h5004, 32'h0000_5004, 4'hF, 0, 1);
    drain(32'h4000, 64'hF, ln(0, 32'h4000, 4'hF), 2'b01, 0, "R6 sealed line");
    drain(32'h4000, 64'hF0, ln(1, 32'h4004, 4'hF), 2'b10, 0, "R6 post-barrier entry");
    drain(32'h5000, 64'hF, ln(0, 32'h5000, 4'hF), 2'b01, 0, "R6 same-cycle sealed");
    drain(32'h5000, 64'hF0, ln(1, 32'h5004, 4'hF), 2'b01, 0, "R6 same-cycle new entry");
    expect_empty("R6 drained");

    // R7 full buffer
    for (int k = 0; k < 8; k++) store(32'h10000 + 32'(k*64), 32'(k), 4'hF, 0, 0);
    @(negedge clk);
    st_valid = 1; st_addr = 30'(32'h20000 >> 2); st_data = 32'h99; st_be = 4'hF;
    #1 chk(st_ready == 0, "R7 full rejects new line", 512'(st_ready), 512'(0));
    st_addr = 30'((32'h10000 + 3*64 + 8) >> 2); st_data = 32'h7777_7777;
    #1 chk(st_ready == 1, "R7 full accepts merge", 512'(st_ready), 512'(1));
    @(posedge clk); #1 st_valid = 0;
    drain(32'h10000, 64'hF, ln(0, 0, 4'hF), 2'b01, 0, "R7 head drains");
    store(32'h20000, 32'h99, 4'hF, 0, 0);
    for (int k = 1; k < 8; k++)
      drain(32'h10000 + 32'(k*64), (k == 3) ? 64'hF0F : 64'hF,
            ln(0, 32'(k), 4'hF) | ((k == 3) ? ln(2, 32'h7777_7777, 4'hF) : '0), 2'b01, 0, "R7 FIFO order");
    drain(32'h20000, 64'hF, ln(0, 32'h99, 4'hF), 2'b01, 0, "R7 late line");
    expect_empty("R7 drained");

    // R9 miss holds draining
    store(32'h6000, 32'h6, 4'hF, 0, 0);
    store(32'h7000, 32'h7, 4'hF, 0, 0);
    drain(32'h6000, 64'hF, ln(0, 32'h6, 4'hF), 2'b01, 1, "R9 missed line");
    drain(32'h7000, 64'hF, ln(0, 32'h7, 4'hF), 2'b01, 0, "R9 next after fill");
    expect_empty("R9 drained");

    // R10 in-flight head not merged
    store(32'h8000, 32'h8, 4'hF, 0, 0);
    @(negedge clk);
    chk(lw_mask == 64'hF, "R10 head mask", 512'(lw_mask), 512'(64'hF));
    lw_ready = 1; @(posedge clk); #1 lw_ready = 0;
    store(32'h8004, 32'h84, 4'hF, 0, 0);
    @(negedge clk); rsp_valid = 1; rsp_hit = 1; @(posedge clk); #1 rsp_valid = 0;
    drain(32'h8000, 64'hF0, ln(1, 32'h84, 4'hF), 2'b01, 0, "R10 fresh entry");
    expect_empty("R10 drained");

    // R11 hold while not ready, merge still allowed before acceptance
    store(32'h9000, 32'h90, 4'hF, 0, 0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(lw_valid == 1 && lw_addr == 26'(32'h9000 >> 6), "R11 held presentation", 512'(lw_addr), 512'(32'h9000 >> 6));
    end
    store(32'h9004, 32'h94, 4'hF, 0, 0);
    drain(32'h9000, 64'hFF, ln(0, 32'h90, 4'hF) | ln(1, 32'h94, 4'hF), 2'b01, 0, "R11 merged before accept");
    expect_empty("R11 drained");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule